// File: doc/BRIEF.md
# Cursor and Crosshair Overlay Generator

This block decides, pixel by pixel, whether a raster display shows cursor colour at the current beam position. It receives the screen pixel counters, a seven-bit control word, the programmed cursor position and the corners and size of a crosshair window. It returns one overlay bit per pixel. That bit combines two sources: a 64x64 bitmap cursor read from an external cursor-map memory, and a crosshair made of a horizontal and a vertical line through the cursor position.

The cursor and window coordinates are held in "programmed" space. That space already includes the horizontal blanking and skew offset, the vertical offset, and a constant that depends on the pixel multiplex mode. The block undoes these offsets itself, so host software can load positions computed in the usual way.

Cursor-map words are fetched on demand. The block drives the word address combinationally from the pixel presented in the current cycle. It expects the word on `map_data` one clock later, as a synchronous RAM returns it. The overlay bit appears two clocks after the pixel coordinates.

Top module: `ovl_cursor_overlay`

## Requirements
- R1: Control bit 6 enables the bitmap cursor and bit 5 enables the crosshair. With both bits clear, `cur_pix` is 0.
- R2: With both sources enabled, control bit 4 selects OR (1) or AND (0) of the two sources. With exactly one source enabled, `cur_pix` follows that source whatever bit 4 holds.
- R3: Control bits [3:2] pick the multiplex lag L: 00 gives 37, 01 gives 52 and 10 gives 57. Code 11 is reserved and uses 37.
- R4: A screen pixel (x,y) maps to bitmap column c = x + H_OFF - L - cur_x and row r = y + V_OFF - 32 - cur_y. The bitmap covers the pixel only when both c and r lie in 0..63.
- R5: The word address is r*8 + c/8. Within a word, the pixel at c%8 = k uses bits [2k+1:2k], so the leftmost pixel is in the least significant bits. A pixel is lit when its field is nonzero.
- R6: Control bits [1:0] give a half-width t of 0..3, which is a line width of 1, 3, 5 or 7. The crosshair covers pixels where |c| <= t or |r| <= t.
- R7: The crosshair is drawn only where the window-relative coordinates wc = x + H_OFF - L - win_x and wr = y + V_OFF - 32 - win_y satisfy 0 <= wc < win_w and 0 <= wr < win_h. A window whose four values are all zero draws nothing.
- R8: `map_addr` follows the pixel presented in the same cycle, and `map_data` is used one clock later. `cur_pix` for a pixel appears after the second rising clock edge following it.
- R9: While reset is asserted, `cur_pix` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_x | input | COORD_W | Screen x counter |
| pix_y | input | COORD_W | Screen y counter |
| ctl | input | 7 | Control word: enables, combine, multiplex, thickness |
| cur_x | input | COORD_W | Programmed cursor x |
| cur_y | input | COORD_W | Programmed cursor y |
| win_x | input | COORD_W | Programmed crosshair window x |
| win_y | input | COORD_W | Programmed crosshair window y |
| win_w | input | COORD_W | Crosshair window width |
| win_h | input | COORD_W | Crosshair window height |
| map_addr | output | ADDR_W | Cursor-map word address |
| map_data | input | WORD_W | Cursor-map word, one clock after its address |
| cur_pix | output | 1 | Overlay pixel |

## Verification
The bench builds the block with COORD_W = 8, H_OFF = 20 and V_OFF = 10. With these values the whole bitmap, the window edges and the crosshair lines fit inside a raster of about 88 by 82 pixels, so every pixel of that area can be swept. A small H_OFF makes H_OFF - L negative, which exercises the signed coordinate path. The three multiplex lags then move the bitmap partly off the swept area, so both the clipped edge and the in-map edges are compared. The cursor map in the bench holds an arithmetic pattern with some zero words, so all four field values occur at every pixel slot.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

   localparam int LAG_1TO1 = 37;
   localparam int LAG_4TO1 = 52;
   localparam int LAG_5TO1 = 57;
   localparam int ROW_BIAS = 32;

   typedef enum logic [1:0] {
      MUX_1TO1 = 2'b00,
      MUX_4TO1 = 2'b01,
      MUX_5TO1 = 2'b10,
      MUX_RSVD = 2'b11
   } mux_mode_e;

   // packed MSB first: bit6 bitmap, bit5 crosshair, bit4 combine, [3:2] mux, [1:0] thickness
   typedef struct packed {
      logic      bm_en;
      logic      xh_en;
      logic      or_join;
      mux_mode_e mux;
      logic [1:0] thick;
   } ctl_t;

   function automatic int mux_lag(mux_mode_e m);
      case (m)
         MUX_4TO1: return LAG_4TO1;
         MUX_5TO1: return LAG_5TO1;
         default:  return LAG_1TO1;
      endcase
   endfunction

endpackage

// File: rtl/ovl_axis_rel.sv
module ovl_axis_rel #(
   parameter int COORD_W = 12,
   parameter int EXT_W   = COORD_W + 2
) (
   input  logic [COORD_W-1:0]      pos,
   input  logic [COORD_W-1:0]      anchor,
   input  logic signed [EXT_W-1:0] adj,
   output logic signed [EXT_W-1:0] rel
);

   logic signed [EXT_W-1:0] pos_s;
   logic signed [EXT_W-1:0] anchor_s;

   always_comb begin
      pos_s    = $signed({{(EXT_W-COORD_W){1'b0}}, pos});
      anchor_s = $signed({{(EXT_W-COORD_W){1'b0}}, anchor});
      rel      = pos_s - anchor_s + adj;
   end

endmodule

// File: rtl/ovl_map_fetch.sv
module ovl_map_fetch #(
   parameter int EXT_W  = 14,
   parameter int DIM_W  = 6,
   parameter int SUB_W  = 3,
   parameter int ADDR_W = 2*DIM_W - SUB_W
) (
   input  logic signed [EXT_W-1:0] rel_c,
   input  logic signed [EXT_W-1:0] rel_r,
   output logic                    in_map,
   output logic [ADDR_W-1:0]       addr,
   output logic [SUB_W-1:0]        sub
);

   logic c_in;
   logic r_in;

   always_comb begin
      c_in   = !rel_c[EXT_W-1] && (rel_c[EXT_W-2:DIM_W] == '0);
      r_in   = !rel_r[EXT_W-1] && (rel_r[EXT_W-2:DIM_W] == '0);
      in_map = c_in && r_in;
      addr   = {rel_r[DIM_W-1:0], rel_c[DIM_W-1:SUB_W]};
      sub    = rel_c[SUB_W-1:0];
   end

endmodule

// File: rtl/ovl_field_pick.sv
module ovl_field_pick #(
   parameter int WORD_W   = 16,
   parameter int PIX_BITS = 2,
   parameter int SUB_W    = 3,
   parameter int NFIELD   = WORD_W / PIX_BITS
) (
   input  logic [WORD_W-1:0] word,
   input  logic [SUB_W-1:0]  sub,
   output logic              lit
);

   logic [NFIELD-1:0] fld_nz;

   for (genvar k = 0; k < NFIELD; k++) begin : g_fld
      assign fld_nz[k] = |word[k*PIX_BITS +: PIX_BITS];
   end

   assign lit = fld_nz[sub];

endmodule

// File: rtl/ovl_crosshair.sv
module ovl_crosshair #(
   parameter int COORD_W = 12,
   parameter int EXT_W   = COORD_W + 2
) (
   input  logic signed [EXT_W-1:0] rel_c,
   input  logic signed [EXT_W-1:0] rel_r,
   input  logic signed [EXT_W-1:0] win_c,
   input  logic signed [EXT_W-1:0] win_r,
   input  logic [COORD_W-1:0]      win_w,
   input  logic [COORD_W-1:0]      win_h,
   input  logic [1:0]              thick,
   output logic                    hit
);

   logic signed [EXT_W-1:0] mag_c;
   logic signed [EXT_W-1:0] mag_r;
   logic signed [EXT_W-1:0] half;
   logic signed [EXT_W-1:0] w_s;
   logic signed [EXT_W-1:0] h_s;
   logic                    in_win;
   logic                    on_line;

   always_comb begin
      mag_c   = rel_c[EXT_W-1] ? -rel_c : rel_c;
      mag_r   = rel_r[EXT_W-1] ? -rel_r : rel_r;
      half    = $signed({{(EXT_W-2){1'b0}}, thick});
      w_s     = $signed({{(EXT_W-COORD_W){1'b0}}, win_w});
      h_s     = $signed({{(EXT_W-COORD_W){1'b0}}, win_h});
      in_win  = !win_c[EXT_W-1] && (win_c < w_s) &&
                !win_r[EXT_W-1] && (win_r < h_s);
      on_line = (mag_c <= half) || (mag_r <= half);
      hit     = in_win && on_line;
   end

endmodule

// File: rtl/ovl_cursor_overlay.sv
module ovl_cursor_overlay
   import ovl_pkg::*;
#(
   parameter int COORD_W  = 12,
   parameter int MAP_DIM  = 64,
   parameter int WORD_W   = 16,
   parameter int PIX_BITS = 2,
   parameter int H_OFF    = 412,
   parameter int V_OFF    = 68,
   localparam int DIM_W   = $clog2(MAP_DIM),
   localparam int PPW     = WORD_W / PIX_BITS,
   localparam int SUB_W   = $clog2(PPW),
   localparam int ADDR_W  = 2*DIM_W - SUB_W,
   localparam int EXT_W   = COORD_W + 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [COORD_W-1:0] pix_x,
   input  logic [COORD_W-1:0] pix_y,
   input  logic [6:0]         ctl,
   input  logic [COORD_W-1:0] cur_x,
   input  logic [COORD_W-1:0] cur_y,
   input  logic [COORD_W-1:0] win_x,
   input  logic [COORD_W-1:0] win_y,
   input  logic [COORD_W-1:0] win_w,
   input  logic [COORD_W-1:0] win_h,
   output logic [ADDR_W-1:0]  map_addr,
   input  logic [WORD_W-1:0]  map_data,
   output logic               cur_pix
);

   // elaboration-time parameter checks
   if (WORD_W % PIX_BITS != 0) begin : g_bad_field
      $error("WORD_W must be a multiple of PIX_BITS");
   end
   if ((1 << DIM_W) != MAP_DIM) begin : g_bad_dim
      $error("MAP_DIM must be a power of two");
   end
   if ((1 << SUB_W) != PPW || PPW > MAP_DIM) begin : g_bad_ppw
      $error("pixels per word must be a power of two not above MAP_DIM");
   end
   if (EXT_W - 2 < DIM_W) begin : g_bad_coord
      $error("COORD_W too narrow for MAP_DIM");
   end
   if (H_OFF < 0 || H_OFF >= (1 << COORD_W) || V_OFF < 0 || V_OFF >= (1 << COORD_W)) begin : g_bad_off
      $error("offsets must fit the coordinate width");
   end

   localparam int NAX = 4;

   ctl_t                    c;
   logic signed [EXT_W-1:0] adj_c;
   logic signed [EXT_W-1:0] adj_r;
   logic [COORD_W-1:0]      ax_pos [NAX];
   logic [COORD_W-1:0]      ax_anc [NAX];
   logic signed [EXT_W-1:0] ax_adj [NAX];
   logic signed [EXT_W-1:0] ax_rel [NAX];

   always_comb begin
      c     = ctl_t'(ctl);
      adj_c = EXT_W'(H_OFF) - EXT_W'(mux_lag(c.mux));
      adj_r = EXT_W'(V_OFF) - EXT_W'(ROW_BIAS);
   end

   // axes: 0 cursor column, 1 cursor row, 2 window column, 3 window row
   assign ax_pos[0] = pix_x;  assign ax_anc[0] = cur_x;  assign ax_adj[0] = adj_c;
   assign ax_pos[1] = pix_y;  assign ax_anc[1] = cur_y;  assign ax_adj[1] = adj_r;
   assign ax_pos[2] = pix_x;  assign ax_anc[2] = win_x;  assign ax_adj[2] = adj_c;
   assign ax_pos[3] = pix_y;  assign ax_anc[3] = win_y;  assign ax_adj[3] = adj_r;

   for (genvar a = 0; a < NAX; a++) begin : g_axis
      ovl_axis_rel #(.COORD_W(COORD_W), .EXT_W(EXT_W)) u_rel (
         .pos    (ax_pos[a]),
         .anchor (ax_anc[a]),
         .adj    (ax_adj[a]),
         .rel    (ax_rel[a])
      );
   end

   logic              in_map;
   logic [ADDR_W-1:0] addr_nx;
   logic [SUB_W-1:0]  sub_nx;
   logic              xh_raw;

   ovl_map_fetch #(.EXT_W(EXT_W), .DIM_W(DIM_W), .SUB_W(SUB_W), .ADDR_W(ADDR_W)) u_fetch (
      .rel_c  (ax_rel[0]),
      .rel_r  (ax_rel[1]),
      .in_map (in_map),
      .addr   (addr_nx),
      .sub    (sub_nx)
   );

   ovl_crosshair #(.COORD_W(COORD_W), .EXT_W(EXT_W)) u_xh (
      .rel_c (ax_rel[0]),
      .rel_r (ax_rel[1]),
      .win_c (ax_rel[2]),
      .win_r (ax_rel[3]),
      .win_w (win_w),
      .win_h (win_h),
      .thick (c.thick),
      .hit   (xh_raw)
   );

   assign map_addr = addr_nx;

   // stage 1: decisions that do not need the map word
   logic             s1_bm_en;
   logic             s1_xh_en;
   logic             s1_or;
   logic             s1_bm_in;
   logic             s1_xh;
   logic [SUB_W-1:0] s1_sub;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_bm_en <= 1'b0;
         s1_xh_en <= 1'b0;
         s1_or    <= 1'b0;
         s1_bm_in <= 1'b0;
         s1_xh    <= 1'b0;
         s1_sub   <= '0;
      end else begin
         s1_bm_en <= c.bm_en;
         s1_xh_en <= c.xh_en;
         s1_or    <= c.or_join;
         s1_bm_in <= c.bm_en & in_map;
         s1_xh    <= c.xh_en & xh_raw;
         s1_sub   <= sub_nx;
      end
   end

   // stage 2: field pick from the returned word, combine
   logic lit;
   logic bm_on;
   logic mix;

   ovl_field_pick #(.WORD_W(WORD_W), .PIX_BITS(PIX_BITS), .SUB_W(SUB_W)) u_pick (
      .word (map_data),
      .sub  (s1_sub),
      .lit  (lit)
   );

   always_comb begin
      bm_on = s1_bm_in & lit;
      case ({s1_bm_en, s1_xh_en})
         2'b11:   mix = s1_or ? (bm_on | s1_xh) : (bm_on & s1_xh);
         2'b10:   mix = bm_on;
         2'b01:   mix = s1_xh;
         default: mix = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_pix <= 1'b0;
      else        cur_pix <= mix;
   end

   // R1
   both_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!s1_bm_en && !s1_xh_en) |=> !cur_pix);
   // R2
   or_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_bm_en && s1_xh_en && s1_or && s1_xh) |=> cur_pix);
   // R2
   and_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_bm_en && s1_xh_en && !s1_or && !s1_xh) |=> !cur_pix);
   // R4
   off_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!s1_bm_in && !s1_xh) |=> !cur_pix);
   // R7
   zero_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_x == '0 && win_y == '0 && win_w == '0 && win_h == '0) |-> !xh_raw);

endmodule

// File: tb/ovl_cursor_overlay_test.sv
`timescale 1ns/1ps
module ovl_cursor_overlay_test;

   localparam int CW  = 8;
   localparam int HO  = 20;
   localparam int VO  = 10;
   localparam int AW  = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] pix_x = '0, pix_y = '0;
   logic [6:0]    ctl = '0;
   logic [CW-1:0] cur_x = '0, cur_y = '0, win_x = '0, win_y = '0, win_w = '0, win_h = '0;
   logic [AW-1:0] map_addr;
   logic [15:0]   map_data = '0;
   logic          cur_pix;

   logic [15:0]   mem [512];

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 0;

   always #5 clk = ~clk;

   ovl_cursor_overlay #(.COORD_W(CW), .H_OFF(HO), .V_OFF(VO)) uut (
      .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y), .ctl(ctl),
      .cur_x(cur_x), .cur_y(cur_y), .win_x(win_x), .win_y(win_y),
      .win_w(win_w), .win_h(win_h), .map_addr(map_addr),
      .map_data(map_data), .cur_pix(cur_pix)
   );

   // synchronous cursor-map memory
   always @(posedge clk) map_data <= mem[map_addr];

   task automatic check(string tag, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         if (n_bad <= 20)
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   function automatic int lag_of(logic [6:0] c);
      if (c[3:2] == 2'b01) return 52;
      if (c[3:2] == 2'b10) return 57;
      return 37;
   endfunction

   function automatic int iabs(int v);
      return (v < 0) ? -v : v;
   endfunction

   function automatic bit model(int x, int y);
      int  lg, rc, rr, wc, wr, w, t;
      bit  bm, xh;
      lg = lag_of(ctl);
      rc = x + HO - lg - int'(cur_x);
      rr = y + VO - 32 - int'(cur_y);
      wc = x + HO - lg - int'(win_x);
      wr = y + VO - 32 - int'(win_y);
      t  = int'(ctl[1:0]);
      bm = 0;
      if (rc >= 0 && rc < 64 && rr >= 0 && rr < 64) begin
         w  = int'(mem[rr*8 + rc/8]);
         bm = ((w >> (2*(rc%8))) & 3) != 0;
      end
      xh = (wc >= 0 && wc < int'(win_w) && wr >= 0 && wr < int'(win_h)) &&
           (iabs(rc) <= t || iabs(rr) <= t);
      case ({ctl[6], ctl[5]})
         2'b11:   return ctl[4] ? (bm | xh) : (bm & xh);
         2'b10:   return bm;
         2'b01:   return xh;
         default: return 1'b0;
      endcase
   endfunction

   bit    e0, e1, v0, v1;
   string t0, t1;

   task automatic step_cmp();
      if (v1) check(t1, int'(cur_pix), int'(e1));
      e1 = e0; v1 = v0; t1 = t0;
   endtask

   task automatic sweep(string tag, logic [6:0] c, int cx, int cy,
                        int wx, int wy, int ww, int wh);
      @(negedge clk);
      ctl = c; cur_x = CW'(cx); cur_y = CW'(cy);
      win_x = CW'(wx); win_y = CW'(wy); win_w = CW'(ww); win_h = CW'(wh);
      v0 = 0; v1 = 0;
      for (int y = 26; y < 108; y++) begin
         for (int x = 28; x < 116; x++) begin
            int lg, rc, rr;
            if (!(y == 26 && x == 28)) @(negedge clk);
            step_cmp();
            pix_x = CW'(x); pix_y = CW'(y);
            e0 = model(x, y); v0 = 1; t0 = tag;
            lg = lag_of(c);
            rc = x + HO - lg - cx;
            rr = y + VO - 32 - cy;
            #1;
            // R8 R5: address follows the current pixel
            if (rc >= 0 && rc < 64 && rr >= 0 && rr < 64)
               check("R5/R8 map address", int'(map_addr), rr*8 + rc/8);
         end
      end
      @(negedge clk); step_cmp(); v0 = 0;
      @(negedge clk); step_cmp();
      @(negedge clk); step_cmp();
   endtask

   initial begin
      for (int a = 0; a < 512; a++) begin
         if (a % 13 == 0) mem[a] = 16'h0000;
         else             mem[a] = 16'((a * 40503 + 12345) ^ (a << 7));
      end
      repeat (4) @(negedge clk);
      check("R9 reset output", int'(cur_pix), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 output after reset", int'(cur_pix), 0);

      sweep("R1 R4 R5 bitmap only 1:1",       7'h40, 20, 10, 0, 0, 0, 0);
      sweep("R3 bitmap 4:1 lag",              7'h44, 20, 10, 0, 0, 0, 0);
      sweep("R3 bitmap 5:1 lag",              7'h48, 20, 10, 0, 0, 0, 0);
      sweep("R3 reserved mux as 1:1",         7'h4C, 20, 10, 0, 0, 0, 0);
      sweep("R6 R7 crosshair thin in window", 7'h20, 40, 30, 10, 5, 60, 50);
      sweep("R6 crosshair width 7",           7'h23, 40, 30, 10, 5, 60, 50);
      sweep("R2 OR join width 3",             7'h71, 20, 10, 10, 5, 60, 50);
      sweep("R2 AND join width 5",            7'h62, 20, 10, 10, 5, 60, 50);
      sweep("R1 both disabled",               7'h1F, 20, 10, 10, 5, 60, 50);
      sweep("R7 all-zero window",             7'h22, 20, 10, 0, 0, 0, 0);
      sweep("R2 single crosshair AND mode",   7'h2D, 30, 20, 0, 0, 90, 80);
      sweep("R2 single bitmap OR mode",       7'h53, 30, 20, 0, 0, 90, 80);

      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #1900000;
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule